// File: doc/BRIEF.md
# Bulk OUT Endpoint Receive FIFO

This block holds the bytes that a host sends to a bulk OUT endpoint until firmware picks them up. The serial engine delivers de-serialized bytes one per cycle with a push strobe, marks the last byte of each packet, and says whether the packet arrived intact. Firmware reads the bytes through a small byte-wide register port. Bytes from a packet become visible to firmware only once the packet has ended good.

A programmable watermark raises an interrupt flag when the FIFO fill crosses the watermark. A programmable maximum packet size, in 8-byte units, flags and discards packets that are too long. A flush command empties the store. A stall bit makes the endpoint refuse host traffic. Pushes into a full store are dropped and flagged.

Register map (`reg_addr_i`): 0 = data (a read pops), 1 = committed count, 2 = watermark, 3 = maximum packet size code, 4 = control/status. Control/status bits: 0 = flush (write 1), 1 = stall (read/write), 2 = watermark flag (write 1 to clear), 3 = oversize flag (read-only), 4 = overflow flag (write 1 to clear). Other addresses read 00h.

Top module: `bulk_out_fifo`

## Requirements
- R1: The store holds 16 bytes. The count register (address 1) reports committed bytes, 0 to 16. It changes only when a good packet ends or a byte is popped, not while a packet is still arriving.
- R2: A read of address 0 returns the oldest committed byte and removes it. If no byte is committed, the read returns 00h and changes nothing.
- R3: The watermark register (address 2) resets to 08h. When a byte is accepted while the fill equals the watermark, control bit 2 and `wm_irq_o` are set. Writing 1 to bit 2 clears the flag and leaves the FIFO contents alone.
- R4: The size code register (address 3) resets to 07h, and the packet limit is 8 × (code + 1) bytes. A packet that delivers more bytes than the limit sets control bit 3 and `ovsz_err_o`, and its bytes are discarded at its end. The flag is read-only and is cleared only by a flush.
- R5: Writing 1 to control bit 0 empties the store, drops any packet in progress and clears the oversize flag. Bit 0 always reads 0, and writing 0 to it has no effect.
- R6: Control bit 1 is the stall bit and drives `stall_o`. While it is set, pushes and packet ends are ignored.
- R7: A push into a full store is dropped and sets control bit 4 and `overflow_o`. Writing 1 to bit 4 clears the flag.
- R8: When a packet ends with `rx_good_i` low, its bytes are rolled back and the count is unchanged.
- R9: A pop and a push in the same cycle both take effect.
- R10: After reset the count is 0, all flags and the stall bit are 0, and every status output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_push_i | input | 1 | Byte strobe from the serial engine |
| rx_data_i | input | 8 | Received byte |
| rx_eop_i | input | 1 | Packet ends this cycle (includes any byte pushed in the same cycle) |
| rx_good_i | input | 1 | Packet passed its integrity check; sampled with rx_eop_i |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, valid in the cycle of the read |
| stall_o | output | 1 | Endpoint answers host writes with STALL |
| wm_irq_o | output | 1 | Watermark flag |
| ovsz_err_o | output | 1 | Oversize packet flag |
| overflow_o | output | 1 | Dropped byte flag |

## Verification
The serial side can push a byte of a new packet in the same cycle that firmware pops a byte of an earlier, committed packet. The bench provokes this by streaming a second packet through cycles that also read address 0. Each popped byte is checked against the scoreboard entries of the first packet. Afterwards the count must equal the length of the second packet, which shows that neither action lost the other.

// File: rtl/bo_pkg.sv
package bo_pkg;
  typedef enum logic [2:0] {
    RA_DATA   = 3'd0,
    RA_COUNT  = 3'd1,
    RA_WMARK  = 3'd2,
    RA_MAXPKT = 3'd3,
    RA_CTRL   = 3'd4
  } reg_addr_e;

  localparam int CB_FLUSH = 0;
  localparam int CB_STALL = 1;
  localparam int CB_WM    = 2;
  localparam int CB_OVSZ  = 3;
  localparam int CB_OVF   = 4;

  localparam logic [7:0] WMARK_RST  = 8'h08;
  localparam logic [7:0] MAXPKT_RST = 8'h07;
endpackage

// File: rtl/bo_store.sv
module bo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/bo_ptr_ctrl.sv
// Pointer control: speculative write pointer, commit pointer, read pointer.
// DEPTH must be a power of two so the extra pointer bit wraps cleanly.
module bo_ptr_ctrl #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter int CW    = 5,
  parameter int LW    = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          eop_i,
  input  logic          good_i,
  input  logic          pop_i,
  input  logic          flush_i,
  input  logic          stall_i,
  input  logic [DW-1:0] wmark_i,
  input  logic [DW-1:0] maxpkt_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [CW-1:0] cmt_cnt_o,
  output logic          wm_hit_o,
  output logic          ovf_hit_o,
  output logic          ovsz_hit_o
);
  logic [CW-1:0] wr_ptr_q, cmt_ptr_q, rd_ptr_q;
  logic [LW-1:0] pkt_len_q;
  logic          pkt_ovsz_q;

  logic [CW-1:0] fill, wr_next;
  logic [LW-1:0] limit;
  logic          full, acc, wr_ok, pop_ok, eop_v, bad_pkt;

  assign fill      = wr_ptr_q - rd_ptr_q;
  assign cmt_cnt_o = cmt_ptr_q - rd_ptr_q;
  assign full      = (fill == CW'(DEPTH));
  assign limit     = LW'({maxpkt_i, 3'b000}) + LW'(8);

  assign acc       = push_i && !stall_i && !flush_i;
  assign wr_ok     = acc && !full;
  assign pop_ok    = pop_i && (cmt_cnt_o != '0) && !flush_i;
  assign eop_v     = eop_i && !stall_i && !flush_i;
  assign wr_next   = wr_ptr_q + CW'(wr_ok);

  assign ovf_hit_o  = acc && full;
  assign ovsz_hit_o = acc && (pkt_len_q >= limit);
  assign wm_hit_o   = wr_ok && (DW'(fill) == wmark_i);
  assign bad_pkt    = !good_i || pkt_ovsz_q || ovsz_hit_o;

  assign wr_en_o   = wr_ok;
  assign wr_addr_o = wr_ptr_q[AW-1:0];
  assign rd_addr_o = rd_ptr_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      cmt_ptr_q  <= '0;
      rd_ptr_q   <= '0;
      pkt_len_q  <= '0;
      pkt_ovsz_q <= 1'b0;
    end else if (flush_i) begin
      wr_ptr_q   <= '0;
      cmt_ptr_q  <= '0;
      rd_ptr_q   <= '0;
      pkt_len_q  <= '0;
      pkt_ovsz_q <= 1'b0;
    end else begin
      rd_ptr_q <= rd_ptr_q + CW'(pop_ok);
      if (eop_v) begin
        if (bad_pkt) begin
          wr_ptr_q <= cmt_ptr_q;
        end else begin
          wr_ptr_q  <= wr_next;
          cmt_ptr_q <= wr_next;
        end
        pkt_len_q  <= '0;
        pkt_ovsz_q <= 1'b0;
      end else begin
        wr_ptr_q <= wr_next;
        if (acc && (pkt_len_q != '1)) pkt_len_q <= pkt_len_q + LW'(1);
        if (ovsz_hit_o) pkt_ovsz_q <= 1'b1;
      end
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_cnt_o <= CW'(DEPTH)) && (fill <= CW'(DEPTH)));
  // R2
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cmt_cnt_o == '0 && !flush_i) |=> $stable(rd_ptr_q));
  // R5
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cmt_cnt_o == '0) && (fill == '0));
  // R6
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !flush_i) |=> $stable(wr_ptr_q) && $stable(cmt_ptr_q));
  // R8
  rollback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eop_v && !good_i) |=> (wr_ptr_q == $past(cmt_ptr_q)) && $stable(cmt_ptr_q));
endmodule

// File: rtl/bo_csr.sv
module bo_csr
  import bo_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] fifo_data_i,
  input  logic [CW-1:0] cmt_cnt_i,
  input  logic          wm_hit_i,
  input  logic          ovf_hit_i,
  input  logic          ovsz_hit_i,
  output logic          pop_o,
  output logic          flush_o,
  output logic          stall_o,
  output logic [DW-1:0] wmark_o,
  output logic [DW-1:0] maxpkt_o,
  output logic          wm_flag_o,
  output logic          ovsz_flag_o,
  output logic          ovf_flag_o
);
  logic ctrl_we;

  assign ctrl_we = we_i && (addr_i == RA_CTRL);
  assign pop_o   = re_i && (addr_i == RA_DATA);
  assign flush_o = ctrl_we && wdata_i[CB_FLUSH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wmark_o     <= DW'(WMARK_RST);
      maxpkt_o    <= DW'(MAXPKT_RST);
      stall_o     <= 1'b0;
      wm_flag_o   <= 1'b0;
      ovsz_flag_o <= 1'b0;
      ovf_flag_o  <= 1'b0;
    end else begin
      if (we_i && addr_i == RA_WMARK)  wmark_o  <= wdata_i;
      if (we_i && addr_i == RA_MAXPKT) maxpkt_o <= wdata_i;
      if (ctrl_we) stall_o <= wdata_i[CB_STALL];
      // set wins over a same-cycle clear
      if (wm_hit_i)                         wm_flag_o <= 1'b1;
      else if (ctrl_we && wdata_i[CB_WM])   wm_flag_o <= 1'b0;
      if (ovsz_hit_i)                       ovsz_flag_o <= 1'b1;
      else if (flush_o)                     ovsz_flag_o <= 1'b0;
      if (ovf_hit_i)                        ovf_flag_o <= 1'b1;
      else if (ctrl_we && wdata_i[CB_OVF])  ovf_flag_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_DATA:   rdata_o = (cmt_cnt_i != '0) ? fifo_data_i : '0;
      RA_COUNT:  rdata_o = DW'(cmt_cnt_i);
      RA_WMARK:  rdata_o = wmark_o;
      RA_MAXPKT: rdata_o = maxpkt_o;
      RA_CTRL: begin
        rdata_o[CB_STALL] = stall_o;
        rdata_o[CB_WM]    = wm_flag_o;
        rdata_o[CB_OVSZ]  = ovsz_flag_o;
        rdata_o[CB_OVF]   = ovf_flag_o;
      end
      default: rdata_o = '0;
    endcase
  end

  // R3
  wm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wm_flag_o) |-> $past(wm_hit_i));
  // R4
  ovsz_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovsz_flag_o) |-> $past(flush_o));
  // R7
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_hit_i |=> ovf_flag_o);
endmodule

// File: rtl/bulk_out_fifo.sv
module bulk_out_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_eop_i,
  input  logic          rx_good_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          stall_o,
  output logic          wm_irq_o,
  output logic          ovsz_err_o,
  output logic          overflow_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int LW = DW + 4;

  logic          wr_en, pop, flush, wm_hit, ovf_hit, ovsz_hit;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] cmt_cnt;
  logic [DW-1:0] fifo_data, wmark, maxpkt;

  bo_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (rx_data_i),
    .raddr_i (rd_addr),
    .rdata_o (fifo_data)
  );

  bo_ptr_ctrl #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .CW(CW), .LW(LW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (rx_push_i),
    .eop_i      (rx_eop_i),
    .good_i     (rx_good_i),
    .pop_i      (pop),
    .flush_i    (flush),
    .stall_i    (stall_o),
    .wmark_i    (wmark),
    .maxpkt_i   (maxpkt),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .rd_addr_o  (rd_addr),
    .cmt_cnt_o  (cmt_cnt),
    .wm_hit_o   (wm_hit),
    .ovf_hit_o  (ovf_hit),
    .ovsz_hit_o (ovsz_hit)
  );

  bo_csr #(.DW(DW), .CW(CW)) u_csr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .re_i        (reg_re_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .fifo_data_i (fifo_data),
    .cmt_cnt_i   (cmt_cnt),
    .wm_hit_i    (wm_hit),
    .ovf_hit_i   (ovf_hit),
    .ovsz_hit_i  (ovsz_hit),
    .pop_o       (pop),
    .flush_o     (flush),
    .stall_o     (stall_o),
    .wmark_o     (wmark),
    .maxpkt_o    (maxpkt),
    .wm_flag_o   (wm_irq_o),
    .ovsz_flag_o (ovsz_err_o),
    .ovf_flag_o  (overflow_o)
  );
endmodule

// File: tb/tb_bulk_out_fifo.sv
`timescale 1ns/1ps
module tb_bulk_out_fifo;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_push_i = 1'b0, rx_eop_i = 1'b0, rx_good_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       stall_o, wm_irq_o, ovsz_err_o, overflow_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q [$];

  bulk_out_fifo dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic cpu_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(posedge clk_i); #1;
    reg_re_i = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] d, input logic eop, input logic good);
    @(negedge clk_i);
    rx_push_i = 1'b1; rx_data_i = d; rx_eop_i = eop; rx_good_i = good;
    @(posedge clk_i); #1;
    rx_push_i = 1'b0; rx_eop_i = 1'b0; rx_good_i = 1'b0;
  endtask

  task automatic eop_only(input logic good);
    @(negedge clk_i);
    rx_eop_i = 1'b1; rx_good_i = good;
    @(posedge clk_i); #1;
    rx_eop_i = 1'b0; rx_good_i = 1'b0;
  endtask

  // driver: pushes a packet, enqueues expected bytes when it should commit
  task automatic send_pkt(input int n, input logic [7:0] base, input logic good, input logic keep);
    for (int i = 0; i < n; i++) begin
      push_byte(base + 8'(i), (i == n - 1), good);
      if (keep) exp_q.push_back(base + 8'(i));
    end
  endtask

  // monitor: pops and compares against the scoreboard
  task automatic drain(input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      cpu_rd(3'd0, d);
      if (exp_q.size() != 0) check(d, exp_q.pop_front(), tag);
      else check(d, 8'hxx, {tag, " (scoreboard empty)"});
    end
  endtask

  task automatic push_pop(input logic [7:0] d, input logic eop, output logic [7:0] got);
    @(negedge clk_i);
    rx_push_i = 1'b1; rx_data_i = d; rx_eop_i = eop; rx_good_i = 1'b1;
    reg_re_i = 1'b1; reg_addr_i = 3'd0;
    #1 got = reg_rdata_o;
    @(posedge clk_i); #1;
    rx_push_i = 1'b0; rx_eop_i = 1'b0; rx_good_i = 1'b0; reg_re_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [7:0] got;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R10 reset state
    cpu_rd(3'd1, d); check(d, 8'h00, "R10 count after reset");
    cpu_rd(3'd4, d); check(d, 8'h00, "R10 ctrl after reset");
    check({4'h0, stall_o, wm_irq_o, ovsz_err_o, overflow_o}, 8'h00, "R10 outputs after reset");
    cpu_rd(3'd2, d); check(d, 8'h08, "R3 watermark reset");
    cpu_rd(3'd3, d); check(d, 8'h07, "R4 size code reset");

    // R1 count holds until good end
    for (int i = 0; i < 3; i++) push_byte(8'h10 + 8'(i), 1'b0, 1'b0);
    cpu_rd(3'd1, d); check(d, 8'h00, "R1 count before end of packet");
    push_byte(8'h13, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) exp_q.push_back(8'h10 + 8'(i));
    cpu_rd(3'd1, d); check(d, 8'h04, "R1 count after good end");
    drain(4, "R2 pop order");
    cpu_rd(3'd0, d); check(d, 8'h00, "R2 pop from empty");
    cpu_rd(3'd1, d); check(d, 8'h00, "R2 count after empty pop");

    // R8 bad packet rolled back
    send_pkt(3, 8'h20, 1'b0, 1'b0);
    cpu_rd(3'd1, d); check(d, 8'h00, "R8 count after bad packet");
    send_pkt(2, 8'h30, 1'b1, 1'b1);
    cpu_rd(3'd1, d); check(d, 8'h02, "R8 count after following good packet");
    drain(2, "R8 data after rollback");

    // R3 watermark crossing
    cpu_wr(3'd2, 8'h03);
    for (int i = 0; i < 3; i++) push_byte(8'h40 + 8'(i), 1'b0, 1'b0);
    check({7'h0, wm_irq_o}, 8'h00, "R3 flag before crossing");
    push_byte(8'h43, 1'b0, 1'b0);
    check({7'h0, wm_irq_o}, 8'h01, "R3 flag on crossing");
    push_byte(8'h44, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) exp_q.push_back(8'h40 + 8'(i));
    cpu_wr(3'd4, 8'h04);
    check({7'h0, wm_irq_o}, 8'h00, "R3 flag cleared by write 1");
    cpu_rd(3'd1, d); check(d, 8'h05, "R3 clear keeps contents");
    drain(5, "R3 data after clear");
    cpu_wr(3'd2, 8'hFF);

    // R9 pop and push in the same cycle
    send_pkt(4, 8'h50, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      push_pop(8'h60 + 8'(i), (i == 3), got);
      check(got, exp_q.pop_front(), "R9 pop during push");
    end
    for (int i = 0; i < 4; i++) exp_q.push_back(8'h60 + 8'(i));
    cpu_rd(3'd1, d); check(d, 8'h04, "R9 count after overlap");
    drain(4, "R9 second packet data");

    // R4 oversize with limit 8
    cpu_wr(3'd3, 8'h00);
    for (int i = 0; i < 9; i++) begin
      push_byte(8'h70 + 8'(i), (i == 8), 1'b1);
      if (i == 7) check({7'h0, ovsz_err_o}, 8'h00, "R4 no flag at limit");
    end
    check({7'h0, ovsz_err_o}, 8'h01, "R4 flag past limit");
    cpu_rd(3'd1, d); check(d, 8'h00, "R4 oversize packet discarded");
    cpu_wr(3'd4, 8'h08);
    check({7'h0, ovsz_err_o}, 8'h01, "R4 flag is read-only");
    cpu_wr(3'd4, 8'h01);
    check({7'h0, ovsz_err_o}, 8'h00, "R4 flush clears flag");
    send_pkt(8, 8'h80, 1'b1, 1'b1);
    cpu_rd(3'd1, d); check(d, 8'h08, "R4 packet at limit kept");
    check({7'h0, ovsz_err_o}, 8'h00, "R4 no flag for exact limit");
    drain(8, "R4 data at limit");
    cpu_wr(3'd3, 8'h07);

    // R5 flush
    send_pkt(3, 8'h90, 1'b1, 1'b1);
    push_byte(8'h93, 1'b0, 1'b0);
    push_byte(8'h94, 1'b0, 1'b0);
    cpu_wr(3'd4, 8'h01);
    exp_q.delete();
    cpu_rd(3'd1, d); check(d, 8'h00, "R5 count after flush");
    cpu_rd(3'd4, d); check(d, 8'h00, "R5 flush bit reads 0");
    eop_only(1'b1);
    cpu_rd(3'd1, d); check(d, 8'h00, "R5 in-progress packet dropped");
    send_pkt(2, 8'hA0, 1'b1, 1'b1);
    cpu_wr(3'd4, 8'h00);
    cpu_rd(3'd1, d); check(d, 8'h02, "R5 write 0 has no effect");
    drain(2, "R5 data after write 0");

    // R6 stall
    cpu_wr(3'd4, 8'h02);
    check({7'h0, stall_o}, 8'h01, "R6 stall output");
    cpu_rd(3'd4, d); check(d, 8'h02, "R6 stall bit readback");
    send_pkt(3, 8'hB0, 1'b1, 1'b0);
    cpu_rd(3'd1, d); check(d, 8'h00, "R6 pushes ignored while stalled");
    cpu_wr(3'd4, 8'h00);
    check({7'h0, stall_o}, 8'h00, "R6 stall released");

    // R7 overflow
    send_pkt(16, 8'hC0, 1'b1, 1'b1);
    cpu_rd(3'd1, d); check(d, 8'h10, "R1 count full");
    push_byte(8'hEE, 1'b1, 1'b1);
    check({7'h0, overflow_o}, 8'h01, "R7 overflow flag");
    cpu_rd(3'd1, d); check(d, 8'h10, "R7 dropped byte not counted");
    drain(16, "R7 data after overflow");
    cpu_wr(3'd4, 8'h10);
    check({7'h0, overflow_o}, 8'h00, "R7 flag cleared by write 1");

    finish_run();
  end
endmodule